// File: doc/BRIEF.md
# Byte-Wide Static Memory Port with Write Protection

This block is a byte-wide static memory, 2^ADDR_W bytes deep, driven by three asynchronous active-low strobes: a select, a read-drive enable and a write strobe. A fast system clock samples the strobes, and the write-protect line from a power supervisor, through a two-stage synchronizer. Each write window is found from those samples, and the block decides cycle by cycle whether a read may drive the output bus or a write may land in the array. The full configuration uses 13 address bits (8192 bytes). The default build uses 10 address bits to keep elaboration small.

The write window is the overlap of select and write strobe. It opens on whichever of the two falls last and closes on whichever rises first. The data present when the window closes is stored at the address present when it opened. After each write the write strobe must stay high for REC_CYC sampled cycles before a new window is accepted. While write-protect is high the block ignores its inputs and keeps the bus released. Read data comes straight from the array, or one cycle later when REG_READ is set.

Top module: `bsram_ctl`

## Requirements
- R1: A byte written at an address is returned unchanged by a later read of that address, and other addresses keep their contents.
- R2: `dout_oe` is 1 only while ce_n=0, oe_n=0, we_n=1 and wp=0, and no write window or recovery is in progress. Whenever `dout_oe` is 0, `dout` reads 0. Both are 0 after reset.
- R3: Pulling we_n low during an active read turns `dout_oe` off.
- R4: A write takes place only while ce_n and we_n are both low. It works with either strobe falling last and either strobe rising first. we_n low with ce_n high stores nothing.
- R5: A window that opens before we_n has been high for REC_CYC sampled cycles after the previous write is discarded. So is a window that opens during that recovery and stays open.
- R6: While wp=1, `dout_oe` stays 0 and no strobe pattern changes the array.
- R7: A write whose window is open when wp rises is discarded. This includes the case where wp rises in the same sampled cycle as the window closing.
- R8: The stored byte is the `din` value sampled when the window closes, and it goes to the address sampled when the window opens. If the address changes while the window is open, `addr_err` pulses high for one cycle just after the write commits.
- R9: Pin changes reach the logic through two flops: a read set up just before a clock edge shows `dout_oe`=0 after that edge and 1 after the next (REG_READ=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Read drive enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| wp | input | 1 | Write protect from the supply supervisor, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_oe | output | 1 | High when `dout` should drive the bus |
| addr_err | output | 1 | One-cycle pulse: the address moved during the last write window |

## Verification
Two pairs of events can land in the same sampled cycle. The first is write-protect rising together with the window closing, where the commit and the abort compete. The bench sets wp=1 and we_n=1 on the same falling clock edge, so both reach the synchronizer output together, and then expects the old byte on read-back. The second is we_n falling during an active read, which both disables the drivers and opens a write. The bench expects `dout_oe` low and the new byte on read-back. Random writes with both strobe orders, mixed with these directed cases, are checked against a byte model kept in the bench.

// File: rtl/bsram_ctl_pkg.sv
// Shared types for the byte-wide memory port.
// Assumes: strobes are converted to active-high before entering these types.
package bsram_ctl_pkg;

    // Controller phase: waiting, write window open, write-strobe recovery.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WRITE   = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    // Control strobes, active high, in synchronizer order.
    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
        logic prot;
    } strobe_t;

endpackage

// File: rtl/bsram_ctl_sync.sv
// Multi-stage flop synchronizer for a bus of asynchronous inputs.
// Assumes: each bit is independently sampled; bits that must stay coherent
// are stable for several clock cycles around their changes.
module bsram_ctl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the sampled inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/bsram_ctl_fsm.sv
// Window detector and write sequencer.
// Opens a write on a fresh rise of (select & write), commits on its close,
// aborts on protect, then enforces a write-strobe recovery interval.
// Assumes: all inputs come from the same synchronizer depth.
module bsram_ctl_fsm
    import bsram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int REC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic              prot_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active,
    output logic              open_evt,
    output logic              in_write,
    output logic              addr_err
);

    localparam int CNT_W = $clog2(REC_CYC + 1);

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  rec_cnt_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic              moved_q;
    logic              win, win_q;
    logic              closing;

    assign win      = sel_s & wr_s;
    assign open_evt = (phase_q == PH_IDLE) & ~prot_s & win & ~win_q;
    assign closing  = (phase_q == PH_WRITE) & ~prot_s & ~win;
    assign in_write = (phase_q == PH_WRITE);

    // Next phase from the sampled strobes.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (open_evt) phase_d = PH_WRITE;
            PH_WRITE:   if (prot_s) phase_d = PH_IDLE;
                        else if (!win) phase_d = PH_RECOVER;
            PH_RECOVER: if (prot_s) phase_d = PH_IDLE;
                        else if (rec_cnt_q == '0 && !wr_s) phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
        endcase
    end

    // Phase, window history and recovery counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            win_q     <= 1'b0;
            rec_cnt_q <= '0;
        end else begin
            phase_q <= phase_d;
            win_q   <= win;
            if (closing)
                rec_cnt_q <= CNT_W'(REC_CYC - 1);
            else if (phase_q == PH_RECOVER) begin
                if (wr_s) rec_cnt_q <= CNT_W'(REC_CYC - 1);
                else if (rec_cnt_q != '0) rec_cnt_q <= rec_cnt_q - 1'b1;
            end
        end
    end

    // Address latched at window open, and address-movement tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_q <= '0;
            moved_q    <= 1'b0;
            addr_err   <= 1'b0;
        end else begin
            addr_err <= closing & moved_q;
            if (open_evt) begin
                lat_addr_q <= addr_s;
                moved_q    <= 1'b0;
            end else if (in_write && win && addr_s != lat_addr_q) begin
                moved_q <= 1'b1;
            end
        end
    end

    assign wr_en     = closing;
    assign wr_addr   = lat_addr_q;
    assign wr_data   = din_s;
    assign rd_active = (phase_q == PH_IDLE) & sel_s & rd_s & ~wr_s & ~prot_s;

endmodule

// File: rtl/bsram_ctl_array.sv
// Byte array with one write port and one read port.
// REG_READ=0 gives a combinational read; REG_READ=1 adds one register.
// Assumes: array contents are not reset; only the read outputs are.
module bsram_ctl_array #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int REG_READ = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit a write into the array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    if (REG_READ != 0) begin : g_reg_read
        // Register the read result and its drive enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data <= '0;
                rd_oe   <= 1'b0;
            end else begin
                rd_data <= rd_en ? mem[rd_addr] : '0;
                rd_oe   <= rd_en;
            end
        end
    end else begin : g_comb_read
        assign rd_oe   = rd_en & rst_n;
        assign rd_data = rd_oe ? mem[rd_addr] : '0;
    end

endmodule

// File: rtl/bsram_ctl.sv
// Top of the byte-wide memory port: synchronizes strobes, address and data,
// sequences writes and gates reads.
// Assumes: address and data are stable while the strobes that use them are
// active, apart from the address moves that R8 flags.
module bsram_ctl
    import bsram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int REC_CYC  = 4,
    parameter int REG_READ = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              addr_err
);

    localparam int SW = $bits(strobe_t);
    localparam int PW = ADDR_W + DATA_W;

    strobe_t           strobe_raw, strobe_s;
    logic [SW-1:0]     strobe_vec;
    logic [PW-1:0]     bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              we_s, wp_s;
    logic              wr_en, rd_active, open_evt, in_write;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    // Convert pin polarity to active-high strobes.
    always_comb begin
        strobe_raw.sel  = ~ce_n;
        strobe_raw.rd   = ~oe_n;
        strobe_raw.wr   = ~we_n;
        strobe_raw.prot = wp;
    end

    bsram_ctl_sync #(.W(SW), .STAGES(2)) strobe_sync_i (
        .clk(clk), .rst_n(rst_n), .d(strobe_raw), .q(strobe_vec)
    );

    bsram_ctl_sync #(.W(PW), .STAGES(2)) bus_sync_i (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
    );

    assign strobe_s         = strobe_t'(strobe_vec);
    assign {addr_s, din_s}  = bus_s;
    assign we_s             = strobe_s.wr;
    assign wp_s             = strobe_s.prot;

    bsram_ctl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_CYC(REC_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .sel_s(strobe_s.sel), .rd_s(strobe_s.rd), .wr_s(we_s), .prot_s(wp_s),
        .addr_s(addr_s), .din_s(din_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_active(rd_active), .open_evt(open_evt), .in_write(in_write),
        .addr_err(addr_err)
    );

    bsram_ctl_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_READ(REG_READ)) array_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_active), .rd_addr(addr_s),
        .rd_data(dout), .rd_oe(dout_oe)
    );

endmodule

// File: rtl/bsram_ctl_chk.sv
// Protocol checker bound to bsram_ctl: output disable, protection,
// recovery spacing and address-error timing.
// Assumes: observes the top's synchronized strobes and sequencer events.
module bsram_ctl_chk #(
    parameter int REC_CYC  = 4,
    parameter int REG_READ = 0
) (
    input logic clk,
    input logic rst_n,
    input logic we_s,
    input logic wp_s,
    input logic wr_en,
    input logic open_evt,
    input logic in_write,
    input logic dout_oe,
    input logic addr_err
);

    localparam int CW = $clog2(REC_CYC + 1) + 1;

    logic [CW-1:0] since_wr;

    // Count cycles since the last commit, saturating at the recovery length.
    always_ff @(posedge clk) begin
        if (!rst_n) since_wr <= CW'(REC_CYC);
        else if (wr_en) since_wr <= '0;
        else if (since_wr < CW'(REC_CYC)) since_wr <= since_wr + 1'b1;
    end

    assert_we_blocks_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_READ == 0 && we_s) |-> !dout_oe);
    assert_we_blocks_drive_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_READ != 0 && we_s) |=> !dout_oe);
    assert_protect_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_READ == 0 && wp_s) |-> !dout_oe);
    assert_recovery_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        open_evt |-> since_wr >= CW'(REC_CYC));
    assert_commit_leaves_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !in_write);
    assert_err_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $past(wr_en));

endmodule

bind bsram_ctl bsram_ctl_chk #(.REC_CYC(REC_CYC), .REG_READ(REG_READ)) chk_i (
    .clk(clk), .rst_n(rst_n), .we_s(we_s), .wp_s(wp_s), .wr_en(wr_en),
    .open_evt(open_evt), .in_write(in_write), .dout_oe(dout_oe),
    .addr_err(addr_err)
);

// File: tb/bsram_ctl_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random writes,
// compared against a byte model held in the bench.
module bsram_ctl_tb_top;

    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe, addr_err;

    int n_checks = 0;
    int n_err    = 0;
    int err_pulses = 0;
    logic [DW-1:0] mdl [int];

    always #10 clk = ~clk;

    bsram_ctl #(.ADDR_W(AW), .DATA_W(DW), .REC_CYC(REC), .REG_READ(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp(wp), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .addr_err(addr_err)
    );

    // Count address-error pulses.
    always @(posedge clk) if (rst_n && addr_err) err_pulses++;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    // Full write; mode 0: WE falls last and rises first, mode 1: CE does.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int mode);
        @(negedge clk); addr = a; din = d;
        @(negedge clk); if (mode == 0) ce_n = 1'b0; else we_n = 1'b0;
        wait_n(2);      if (mode == 0) we_n = 1'b0; else ce_n = 1'b0;
        wait_n(3);      if (mode == 0) we_n = 1'b1; else ce_n = 1'b1;
        wait_n(2);      ce_n = 1'b1; we_n = 1'b1;
        wait_n(REC + 4);
        mdl[int'(a)] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        wait_n(3);
        check(dout_oe === 1'b1, req, dout_oe, 1);
        check(dout === mdl[int'(a)], req, dout, mdl[int'(a)]);
        idle_pins();
        wait_n(3);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int e0;
        void'($urandom(32'd4321));
        wait_n(4);
        // R2: reset state
        check(dout_oe === 1'b0, "R2 reset oe", dout_oe, 0);
        check(dout === '0, "R2 reset dout", dout, 0);
        check(addr_err === 1'b0, "R2 reset err", addr_err, 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(3);

        // R1 / R4: both strobe orders
        do_write(10'd100, 8'hA5, 0);
        do_write(10'd101, 8'h3C, 1);
        do_write(10'd102, 8'h11, 0);
        do_write(10'd103, 8'h22, 1);
        do_write(10'd104, 8'h33, 0);
        do_read(10'd100, "R1 R4 we-controlled");
        do_read(10'd101, "R1 R4 ce-controlled");

        // R9: two-flop latency on the read path
        @(negedge clk); addr = 10'd100; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); check(dout_oe === 1'b0, "R9 after one edge", dout_oe, 0);
        @(negedge clk); check(dout_oe === 1'b1, "R9 after two edges", dout_oe, 1);
        idle_pins(); wait_n(3);

        // R2: OE high gives no drive and zero data
        @(negedge clk); addr = 10'd100; ce_n = 1'b0; oe_n = 1'b1;
        wait_n(3);
        check(dout_oe === 1'b0, "R2 oe high", dout_oe, 0);
        check(dout === '0, "R2 undriven dout", dout, 0);
        idle_pins(); wait_n(3);

        // R4: WE low with CE high writes nothing
        @(negedge clk); addr = 10'd102; din = 8'hEE; we_n = 1'b0;
        wait_n(4); we_n = 1'b1; wait_n(REC + 4);
        do_read(10'd102, "R4 ce high no write");

        // R3: WE falling during read disables drive and writes
        @(negedge clk); addr = 10'd103; ce_n = 1'b0; oe_n = 1'b0;
        wait_n(3);
        check(dout_oe === 1'b1, "R3 read active", dout_oe, 1);
        @(negedge clk); din = 8'h5A; we_n = 1'b0;
        wait_n(3);
        check(dout_oe === 1'b0, "R3 we disables drive", dout_oe, 0);
        we_n = 1'b1; wait_n(2); idle_pins(); wait_n(REC + 4);
        mdl[103] = 8'h5A;
        do_read(10'd103, "R3 R8 write during read");

        // R5: window reopened inside recovery is discarded
        @(negedge clk); addr = 10'd100; din = 8'h77;
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
        wait_n(3); we_n = 1'b1;
        @(negedge clk); addr = 10'd104; din = 8'hC3; we_n = 1'b0;
        wait_n(4); we_n = 1'b1; wait_n(2); ce_n = 1'b1; wait_n(REC + 4);
        mdl[100] = 8'h77;
        do_read(10'd104, "R5 early window discarded");
        do_read(10'd100, "R5 first write kept");

        // R6: protect floats outputs and blocks writes
        @(negedge clk); wp = 1'b1; wait_n(3);
        @(negedge clk); addr = 10'd101; ce_n = 1'b0; oe_n = 1'b0;
        wait_n(3);
        check(dout_oe === 1'b0, "R6 protect floats", dout_oe, 0);
        @(negedge clk); oe_n = 1'b1; din = 8'h99; we_n = 1'b0;
        wait_n(4); we_n = 1'b1; wait_n(2); ce_n = 1'b1;
        wait_n(3); wp = 1'b0; wait_n(REC + 4);
        do_read(10'd101, "R6 protected write ignored");

        // R7: protect mid-window aborts
        @(negedge clk); addr = 10'd102; din = 8'h44; ce_n = 1'b0; we_n = 1'b0;
        wait_n(3); wp = 1'b1; wait_n(3); we_n = 1'b1; ce_n = 1'b1;
        wait_n(3); wp = 1'b0; wait_n(REC + 4);
        do_read(10'd102, "R7 abort mid-window");

        // R7: protect and close in the same cycle
        @(negedge clk); addr = 10'd104; din = 8'h55; ce_n = 1'b0; we_n = 1'b0;
        wait_n(3); wp = 1'b1; we_n = 1'b1;
        wait_n(3); ce_n = 1'b1; wait_n(2); wp = 1'b0; wait_n(REC + 4);
        do_read(10'd104, "R7 same-cycle protect and close");

        // R8: address moved inside window
        e0 = err_pulses;
        @(negedge clk); addr = 10'd100; din = 8'hB7;
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
        wait_n(3); addr = 10'd101;
        wait_n(3); we_n = 1'b1; wait_n(2); ce_n = 1'b1; wait_n(REC + 4);
        mdl[100] = 8'hB7;
        check(err_pulses == e0 + 1, "R8 addr_err pulse", err_pulses - e0, 1);
        do_read(10'd100, "R8 opening address stored");
        do_read(10'd101, "R8 moved-to address kept");

        // R1 / R4: seeded random writes and reads
        e0 = err_pulses;
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] ra;
            ra = AW'(200 + $urandom_range(0, 15));
            do_write(ra, DW'($urandom), int'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) begin
                logic [AW-1:0] qa;
                qa = AW'(200 + $urandom_range(0, 15));
                if (mdl.exists(int'(qa))) do_read(qa, "R1 random read");
            end
        end
        for (int k = 200; k < 216; k++)
            if (mdl.exists(k)) do_read(AW'(k), "R1 final sweep");
        check(err_pulses == e0, "R8 no error on clean writes", err_pulses - e0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule